// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes a DDR2 memory device from reset to a programmed, ready state. After reset it raises the clock enable, keeps the termination control low, and waits a programmable settling period with no-operation commands on the bus. It then steps through a fixed chain of commands. Each command is followed by its own minimum spacing. The chain is: precharge-all, the extended registers 2, 3 and 1, a main-register write that resets the DLL, a second precharge-all, two refreshes, a main-register write that releases the DLL reset, and two writes of extended register 1 that first load and then leave the default driver-calibration setting.

Configuration inputs supply the burst length code, the burst ordering, the CAS latency code and the write-recovery code. The block packs them into every main-register word it sends. It always writes the whole register. A burst length code other than 4 or 8 is replaced by the code for 4. The driver-calibration step waits for the DLL lock interval to pass after the DLL reset. When the last spacing has run out, the block raises a completion flag and then leaves the bus idle.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `cke`=0, `odt`=0, deselect (`cs_n`,`ras_n`,`cas_n`,`we_n` = 1111), `ba`=0, `addr`=0 and `init_done`=0. This applies also when reset arrives in the middle of a sequence.
- R2: In the first cycle after reset is released, `cke` goes to 1 and stays at 1. Exactly `T_CKE` cycles then separate the rise of `cke` from the first precharge-all.
- R3: Commands are encoded on {`cs_n`,`ras_n`,`cas_n`,`we_n`} as follows: register write 0000, refresh 0001, precharge-all 0010, no-operation 0111. Every cycle that carries no command shows no-operation with `ba`=0 and `addr`=0.
- R4: The command order and bank addresses are: precharge-all, write ba=2, write ba=3, write ba=1, write ba=0 (DLL reset), precharge-all, refresh, refresh, write ba=0, write ba=1 (calibration default), write ba=1 (calibration exit).
- R5: The spacing from one command to the next is exactly `T_RP` after a precharge-all, `T_RFC` after a refresh, and `T_MRD` after a register write. The only exception is the spacing covered by R6.
- R6: The calibration-default write comes at the later of two points: `T_MRD` cycles after the preceding main-register write, or `T_DLL` cycles after the DLL-reset write.
- R7: A main-register word carries the burst length in addr[2:0], the burst ordering in addr[3], the CAS latency in addr[6:4], DLL reset in addr[8] (1 on the first write, 0 on the second) and write recovery in addr[11:9]. Every other bit is 0.
- R8: A burst length code other than 010 or 011 is sent as 010.
- R9: A precharge-all drives addr[10]=1 and all other address bits 0. The calibration-default word is 0x380 (addr[9:7]=111). The words for registers 2 and 3, the first register-1 write and the calibration-exit write are all 0.
- R10: `init_done` rises exactly `T_MRD` cycles after the calibration-exit write. It stays high until reset, and no command follows it.
- R11: `odt` is 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_burst_len | input | 3 | Burst length code (010 = 4, 011 = 8) |
| cfg_burst_intlv | input | 1 | Burst ordering bit |
| cfg_cas_lat | input | 3 | CAS latency code |
| cfg_wr_rec | input | 3 | Write-recovery code |
| cke | output | 1 | Clock enable to the device |
| odt | output | 1 | On-die termination control, held low |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address / register select |
| addr | output | 13 | Address / register data |
| init_done | output | 1 | Initialization complete |

## Verification
Two waits can run out in the same cycle: the DLL lock interval that started at the DLL-reset write, and the `T_MRD` spacing after the second main-register write. Both gate the calibration-default write. The bench chooses `T_DLL` so that both expire on the same edge. At that edge an off-by-one in either wait moves the command by one cycle, and the bench judges the result by comparing the exact cycle of every command with a schedule it computes itself.

// File: rtl/ddr2_init_pkg.sv
// Package: shared command codes, step descriptors and the fixed step table
// for the DDR2 initialization sequencer.
// Assumes: commands are encoded on {cs_n, ras_n, cas_n, we_n}.
package ddr2_init_pkg;

    localparam int ADDR_W    = 13;
    localparam int NUM_STEPS = 11;
    localparam int STEP_W    = 4;

    typedef enum logic [3:0] {
        CMD_MRS   = 4'b0000,
        CMD_REF   = 4'b0001,
        CMD_PREA  = 4'b0010,
        CMD_NOP   = 4'b0111,
        CMD_DESEL = 4'b1111
    } cmd_e;

    typedef enum logic [2:0] {
        WD_ZERO,
        WD_PREA,
        WD_MR_DLLRST,
        WD_MR_RUN,
        WD_OCD_DFLT
    } word_e;

    typedef enum logic [1:0] {
        GAP_RP,
        GAP_MRD,
        GAP_RFC
    } gap_e;

    typedef struct packed {
        cmd_e        cmd;
        logic [1:0]  ba;
        word_e       word;
        gap_e        gap;
        logic        wait_dll;
    } step_t;

    // Returns the command, target, data word kind and trailing gap of a step.
    function automatic step_t step_of(input logic [STEP_W-1:0] idx);
        step_t s;
        case (idx)
            4'd0:    s = '{CMD_PREA, 2'd0, WD_PREA,      GAP_RP,  1'b0};
            4'd1:    s = '{CMD_MRS,  2'd2, WD_ZERO,      GAP_MRD, 1'b0};
            4'd2:    s = '{CMD_MRS,  2'd3, WD_ZERO,      GAP_MRD, 1'b0};
            4'd3:    s = '{CMD_MRS,  2'd1, WD_ZERO,      GAP_MRD, 1'b0};
            4'd4:    s = '{CMD_MRS,  2'd0, WD_MR_DLLRST, GAP_MRD, 1'b0};
            4'd5:    s = '{CMD_PREA, 2'd0, WD_PREA,      GAP_RP,  1'b0};
            4'd6:    s = '{CMD_REF,  2'd0, WD_ZERO,      GAP_RFC, 1'b0};
            4'd7:    s = '{CMD_REF,  2'd0, WD_ZERO,      GAP_RFC, 1'b0};
            4'd8:    s = '{CMD_MRS,  2'd0, WD_MR_RUN,    GAP_MRD, 1'b0};
            4'd9:    s = '{CMD_MRS,  2'd1, WD_OCD_DFLT,  GAP_MRD, 1'b1};
            4'd10:   s = '{CMD_MRS,  2'd1, WD_ZERO,      GAP_MRD, 1'b0};
            default: s = '{CMD_NOP,  2'd0, WD_ZERO,      GAP_MRD, 1'b0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ddr2_gap_timer.sv
// Module: down-counter that measures the spacing after a command.
// Assumes: load_val is the spacing minus one; expired is high when the
// spacing has elapsed and a new command may go out.
module ddr2_gap_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    // Load on a new command, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/ddr2_dll_wait.sv
// Module: tracks the DLL lock interval that starts at the DLL-reset write.
// Assumes: start pulses in the cycle the DLL-reset write is issued; locked
// rises once T_DLL edges have passed since then and holds until reset.
module ddr2_dll_wait #(
    parameter int T_DLL = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic locked
);

    localparam int DW = $clog2(T_DLL + 1);

    logic [DW-1:0] age_q;

    // Start at one on the reset write, then count up and saturate at T_DLL.
    always_ff @(posedge clk) begin
        if (!rst_n)
            age_q <= '0;
        else if (start)
            age_q <= DW'(1);
        else if (age_q != '0 && age_q < DW'(T_DLL))
            age_q <= age_q + 1'b1;
    end

    assign locked = (age_q >= DW'(T_DLL));

endmodule

// File: rtl/ddr2_mode_word.sv
// Module: builds the 13-bit register data word for the current step.
// Assumes: configuration is stable during initialization; illegal burst
// length codes are replaced by the code for length 4.
module ddr2_mode_word
    import ddr2_init_pkg::*;
(
    input  word_e              sel,
    input  logic [2:0]         cfg_burst_len,
    input  logic               cfg_burst_intlv,
    input  logic [2:0]         cfg_cas_lat,
    input  logic [2:0]         cfg_wr_rec,
    output logic [ADDR_W-1:0]  word
);

    logic [2:0] bl_code;

    // Keep only the two legal burst length codes.
    always_comb begin
        bl_code = (cfg_burst_len == 3'b011) ? 3'b011 : 3'b010;
    end

    // Pick the full register image for the requested word kind.
    always_comb begin
        case (sel)
            WD_PREA:      word = 13'h0400;
            WD_MR_DLLRST: word = {1'b0, cfg_wr_rec, 1'b1, 1'b0, cfg_cas_lat,
                                  cfg_burst_intlv, bl_code};
            WD_MR_RUN:    word = {1'b0, cfg_wr_rec, 1'b0, 1'b0, cfg_cas_lat,
                                  cfg_burst_intlv, bl_code};
            WD_OCD_DFLT:  word = 13'h0380;
            default:      word = '0;
        endcase
    end

endmodule

// File: rtl/ddr2_init_seq.sv
// Module: top of the DDR2 power-up initialization sequencer.
// Raises CKE, waits T_CKE cycles of NOP, walks the fixed step table with
// per-step spacing, waits for DLL lock before the calibration step, and
// then flags completion. All outputs are registered.
// Assumes: every spacing parameter is at least 1; cfg_* held stable.
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int T_CKE = 80,
    parameter int T_RP  = 3,
    parameter int T_MRD = 2,
    parameter int T_RFC = 26,
    parameter int T_DLL = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_burst_intlv,
    input  logic [2:0]        cfg_cas_lat,
    input  logic [2:0]        cfg_wr_rec,
    output logic              cke,
    output logic              odt,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    localparam int MAX_A   = (T_CKE > T_RFC) ? T_CKE : T_RFC;
    localparam int MAX_B   = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int MAX_GAP = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW      = $clog2(MAX_GAP + 1);
    localparam int AGE_W   = $clog2(T_DLL + 1);

    typedef enum logic [1:0] {PH_OFF, PH_RUN, PH_TAIL, PH_DONE} phase_e;

    phase_e              phase_q;
    logic [STEP_W-1:0]   step_q;
    step_t               cur;
    logic                expired;
    logic                dll_locked;
    logic                issue;
    logic                load;
    logic [CW-1:0]       load_val;
    logic [CW-1:0]       gap_val;
    logic [ADDR_W-1:0]   word;
    logic [3:0]          cmd_q;
    logic                cke_q;

    // Look up the descriptor of the step waiting to go out.
    always_comb cur = step_of(step_q);

    // Translate the step's spacing kind into a timer reload value.
    always_comb begin
        case (cur.gap)
            GAP_RP:  gap_val = CW'(T_RP - 1);
            GAP_RFC: gap_val = CW'(T_RFC - 1);
            default: gap_val = CW'(T_MRD - 1);
        endcase
    end

    // A step goes out once its spacing has elapsed and any DLL wait is over.
    always_comb begin
        issue    = (phase_q == PH_RUN) && expired && (!cur.wait_dll || dll_locked);
        load     = issue || (phase_q == PH_OFF);
        load_val = (phase_q == PH_OFF) ? CW'(T_CKE - 1) : gap_val;
    end

    ddr2_gap_timer #(.CW(CW)) gap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    ddr2_dll_wait #(.T_DLL(T_DLL)) dll_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (issue && (cur.word == WD_MR_DLLRST)),
        .locked (dll_locked)
    );

    ddr2_mode_word word_i (
        .sel             (cur.word),
        .cfg_burst_len   (cfg_burst_len),
        .cfg_burst_intlv (cfg_burst_intlv),
        .cfg_cas_lat     (cfg_cas_lat),
        .cfg_wr_rec      (cfg_wr_rec),
        .word            (word)
    );

    // Sequencer state: phase, step index, CKE and the done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_OFF;
            step_q    <= '0;
            cke_q     <= 1'b0;
            init_done <= 1'b0;
        end else begin
            case (phase_q)
                PH_OFF: begin
                    cke_q   <= 1'b1;
                    phase_q <= PH_RUN;
                end
                PH_RUN: begin
                    if (issue) begin
                        step_q <= step_q + 1'b1;
                        if (step_q == STEP_W'(NUM_STEPS - 1))
                            phase_q <= PH_TAIL;
                    end
                end
                PH_TAIL: begin
                    if (expired) begin
                        init_done <= 1'b1;
                        phase_q   <= PH_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    // Command bus register: the issued step, or NOP with a quiet address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_DESEL;
            ba    <= '0;
            addr  <= '0;
        end else if (issue) begin
            cmd_q <= cur.cmd;
            ba    <= cur.ba;
            addr  <= word;
        end else begin
            cmd_q <= CMD_NOP;
            ba    <= '0;
            addr  <= '0;
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
    assign cke = cke_q;
    assign odt = 1'b0;

    // ---------------- assertions ----------------
    logic [3:0]       bus_cmd;
    logic             bus_active;
    logic [AGE_W-1:0] chk_age_q;

    assign bus_cmd    = {cs_n, ras_n, cas_n, we_n};
    assign bus_active = !cs_n && (bus_cmd != CMD_NOP);

    // Age of the DLL-reset write as seen on the bus, for the lock check.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chk_age_q <= '0;
        else if (bus_cmd == CMD_MRS && ba == 2'd0 && addr[8])
            chk_age_q <= AGE_W'(1);
        else if (chk_age_q != '0 && chk_age_q < AGE_W'(T_DLL))
            chk_age_q <= chk_age_q + 1'b1;
    end

    // R2
    cmd_needs_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active |-> cke);

    // R11
    odt_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !odt);

    // R9
    prea_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == CMD_PREA) |-> addr[10]);

    // R8
    mr_bl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == CMD_MRS && ba == 2'd0) |-> (addr[2:0] == 3'b010 || addr[2:0] == 3'b011));

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R10
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (bus_cmd == CMD_NOP));

    // R6
    dll_lock_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == CMD_MRS && ba == 2'd1 && addr[9:7] == 3'b111) |-> (chk_age_q >= AGE_W'(T_DLL)));

endmodule

// File: tb/ddr2_init_seq_tb.sv
`timescale 1ns/1ps
module ddr2_init_seq_tb_top;

    localparam int TB_CKE = 8;
    localparam int TB_RP  = 3;
    localparam int TB_MRD = 2;
    localparam int TB_RFC = 6;
    localparam int TB_DLL = 19;   // lock wait ends on the same edge as the tMRD gap
    localparam int NSTEP  = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_burst_len = 3'b010;
    logic        cfg_burst_intlv = 1'b0;
    logic [2:0]  cfg_cas_lat = 3'b011;
    logic [2:0]  cfg_wr_rec = 3'b001;
    logic        cke, odt, cs_n, ras_n, cas_n, we_n, init_done;
    logic [1:0]  ba;
    logic [12:0] addr;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    int exp_t [NSTEP];
    int done_t;

    always #2.5 clk = ~clk;

    ddr2_init_seq #(
        .T_CKE(TB_CKE), .T_RP(TB_RP), .T_MRD(TB_MRD), .T_RFC(TB_RFC), .T_DLL(TB_DLL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_burst_len(cfg_burst_len), .cfg_burst_intlv(cfg_burst_intlv),
        .cfg_cas_lat(cfg_cas_lat), .cfg_wr_rec(cfg_wr_rec),
        .cke(cke), .odt(odt), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .init_done(init_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // R4: expected command code per step
    function automatic logic [3:0] exp_cmd(input int k);
        if (k == 0 || k == 5) return 4'b0010;
        if (k == 6 || k == 7) return 4'b0001;
        return 4'b0000;
    endfunction

    // R4: expected bank address per step
    function automatic logic [1:0] exp_ba(input int k);
        case (k)
            1: return 2'd2;
            2: return 2'd3;
            3, 9, 10: return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    // R7 R8 R9: expected register data per step
    function automatic logic [12:0] exp_word(input int k, input logic [2:0] bl,
                                             input logic bt, input logic [2:0] cl,
                                             input logic [2:0] wr);
        logic [2:0] blc;
        blc = (bl == 3'b011) ? 3'b011 : 3'b010;
        case (k)
            0, 5: return 13'h0400;
            4:    return {1'b0, wr, 1'b1, 1'b0, cl, bt, blc};
            8:    return {1'b0, wr, 1'b0, 1'b0, cl, bt, blc};
            9:    return 13'h0380;
            default: return 13'h0000;
        endcase
    endfunction

    // R2 R5 R6: command schedule counted from the cycle CKE rises
    task automatic build_sched();
        int t;
        t = TB_CKE;
        for (int k = 0; k < NSTEP; k++) begin
            if (k == 9 && t < exp_t[4] + TB_DLL) t = exp_t[4] + TB_DLL;
            exp_t[k] = t;
            if (k == 0 || k == 5)      t = t + TB_RP;
            else if (k == 6 || k == 7) t = t + TB_RFC;
            else                       t = t + TB_MRD;
        end
        done_t = t;
    endtask

    task automatic check_reset_state();
        chk("R1 cke", 32'(cke), 0);
        chk("R1 odt", 32'(odt), 0);
        chk("R1 bus", 32'({cs_n, ras_n, cas_n, we_n}), 32'hF);
        chk("R1 ba/addr", 32'({ba, addr}), 0);
        chk("R1 done", 32'(init_done), 0);
    endtask

    // One full initialization; abort_at >= 0 applies reset at that cycle.
    task automatic run_one(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                           input logic [2:0] wr, input int abort_at);
        int k;
        string tag;
        @(negedge clk);
        rst_n = 1'b0;
        cfg_burst_len = bl; cfg_burst_intlv = bt; cfg_cas_lat = cl; cfg_wr_rec = wr;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        k = 0;
        for (int n = 0; n <= done_t + 6; n++) begin
            @(negedge clk);
            if (abort_at >= 0 && n == abort_at) begin
                rst_n = 1'b0;
                @(negedge clk);
                check_reset_state();   // R1 mid-sequence
                break;
            end
            chk("R2 cke high", 32'(cke), 1);
            chk("R11 odt low", 32'(odt), 0);
            if (k < NSTEP && n == exp_t[k]) begin
                tag = (k == 9) ? "R3 R6 cmd" : (k == 0 ? "R2 R3 cmd" : "R3 R5 cmd");
                chk(tag, 32'({cs_n, ras_n, cas_n, we_n}), 32'(exp_cmd(k)));
                chk("R4 ba", 32'(ba), 32'(exp_ba(k)));
                tag = (k == 4 || k == 8) ? ((bl != 3'b010 && bl != 3'b011) ? "R8 word" : "R7 word")
                                         : "R9 word";
                chk(tag, 32'(addr), 32'(exp_word(k, bl, bt, cl, wr)));
                k++;
            end else begin
                chk("R3 idle nop", 32'({cs_n, ras_n, cas_n, we_n, ba, addr}), 32'({4'b0111, 15'd0}));
            end
            chk("R10 done", 32'(init_done), 32'(n >= done_t));
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 100000) begin
            n_checks++;
            n_errors++;
            $display("FAIL R10 watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0101));
        build_sched();
        // directed corners
        run_one(3'b011, 1'b1, 3'b101, 3'b111, -1);
        run_one(3'b000, 1'b0, 3'b011, 3'b001, -1);   // R8 illegal code
        run_one(3'b111, 1'b1, 3'b100, 3'b010, -1);   // R8 illegal code
        run_one(3'b010, 1'b0, 3'b110, 3'b101, 20);   // R1 reset during sequence
        run_one(3'b010, 1'b0, 3'b110, 3'b101, -1);
        // constrained random configurations
        for (int i = 0; i < 6; i++) begin
            run_one(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                    3'($urandom_range(2, 6)), 3'($urandom_range(1, 5)), -1);
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule